// File: doc/BRIEF.md
# Power-Save Sequencer with Idle Timer

This block sequences the low-power states of a small microcontroller core. Software moves the core from normal execution into a stop state, in which the oscillator is switched off, or into a light-sleep state, in which only the oscillator and a free-running idle timer keep going. Each entry is requested with a one-cycle write strobe. The block drives a core clock enable, an oscillator enable, a one-cycle wake pulse that the core uses to resynchronise before it fetches again, and the enables for the watchdog, the clock monitor and the clock input pad.

The stop state ends on a rising edge of any bit of an external wake port, or on a rising edge of the clock-output pin when the R/C oscillator is in use. The core clock stays gated while the oscillator settles. To time this, the idle timer is reloaded with a settling count and counts one step per instruction cycle, which is the block clock divided by a prescaler. With a crystal or resonator the settling wait is always applied. With the R/C oscillator it is applied only when a delay configuration bit is set. The light-sleep state ends on a wake-port edge, or when a chosen bit of the idle timer toggles. That toggle also latches a timer pending flag, which raises an interrupt request when the timer interrupt enable is set.

Top module: `lp_wake_seq`

## Requirements
- R1: After reset the core clock enable and the oscillator enable are 1, the stop and sleep flags, the pending flag, the interrupt request and the wake pulse are 0, and the settle-delay bit is 0.
- R2: A stop-write strobe while running, with the stop-disable option at 0, sets the stop flag, drops the core clock enable and drops the oscillator enable on the next clock edge.
- R3: While the stop-disable option is 1, a stop-write strobe has no effect: the stop flag stays 0 and the core clock enable stays 1.
- R4: When the settling wait applies, a wake event in the stop state sets the oscillator enable at once but keeps the core clock gated for SETTLE instruction cycles. The core clock enable therefore returns DIV*SETTLE+3 clock edges after the wake input rises (the count includes the 2-flop synchroniser and the edge register).
- R5: With a crystal (cfgRcOsc=0) the settling wait always applies. With the R/C oscillator (cfgRcOsc=1) it applies only when the settle-delay bit is 1; otherwise the core clock enable returns 3 clock edges after the wake input rises.
- R6: A rising edge on ckoPin ends the stop state only when cfgRcOsc=1. With cfgRcOsc=0 the block stays in the stop state.
- R7: A sleep-write strobe while running sets the sleep flag and gates the core clock while the oscillator stays enabled. A wake-port rising edge ends sleep 3 clock edges after the port bit rises, with no settling wait.
- R8: The idle timer counts down once per instruction cycle outside the stop state. Each toggle of bit TOGGLE_BIT sets t0Pnd, which happens every DIV*2^TOGGLE_BIT clocks while running. In the sleep state the toggle also ends sleep in the same edge. A clear strobe resets t0Pnd, and a toggle in the same cycle takes priority over the clear.
- R9: t0Irq is 1 exactly when t0Pnd and t0En are both 1.
- R10: Wake-port edges that arrive while running are ignored and do not end a later sleep.
- R11: In the stop state wdEn is 0 whatever wdEnReq is, and cmEn follows cmEnReq. The clock input is forced high (ckiForceHigh=1) when cfgRcOsc=1, and its driver is disabled (ckiDrvEn=0) when cfgRcOsc=0.
- R12: On every return to running, wakePulse is 1 for exactly one cycle, the first cycle with the core clock enabled, and the stop and sleep flags read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| rstN | input | 1 | Active-low asynchronous reset |
| cfgRcOsc | input | 1 | 1 = R/C oscillator, 0 = crystal or resonator |
| cfgHaltDis | input | 1 | Option bit that disables the stop state |
| swHaltWr | input | 1 | Strobe: request the stop state |
| swIdleWr | input | 1 | Strobe: request the sleep state |
| swPndClr | input | 1 | Strobe: clear the timer pending flag |
| swDlyWr | input | 1 | Strobe: write the settle-delay bit |
| swDlyVal | input | 1 | Value for the settle-delay bit |
| t0En | input | 1 | Timer interrupt enable |
| wdEnReq | input | 1 | Watchdog enable requested by software |
| cmEnReq | input | 1 | Clock monitor enable requested by software |
| wakePort | input | WK_W | Asynchronous wake inputs, rising-edge sensitive |
| ckoPin | input | 1 | Level of the clock-output pin |
| coreClkEn | output | 1 | Core clock enable |
| oscEn | output | 1 | Oscillator enable |
| wakePulse | output | 1 | One-cycle pulse on return to running |
| haltFlag | output | 1 | Stop flag readback (also 1 during settling) |
| idleFlag | output | 1 | Sleep flag readback |
| t0Pnd | output | 1 | Timer pending flag |
| t0Irq | output | 1 | Timer interrupt request |
| wdEn | output | 1 | Effective watchdog enable |
| cmEn | output | 1 | Effective clock monitor enable |
| ckiForceHigh | output | 1 | Force the clock input high internally |
| ckiDrvEn | output | 1 | Clock input driver enable (0 = tri-state) |

## Verification
The bench builds the block with DIV=3, TMR_W=8, TOGGLE_BIT=4, SETTLE=8 and WK_W=4. With these values the settling wait is 27 clocks and the timer period is 48 clocks, so the bench can time every stop exit and every sleep exit to the exact edge and compare the timer period exactly. The shortened period also lets the bench place a sleep entry inside a known quiet window after a toggle. That window is needed to show that a wake edge seen while running has no effect on a later sleep.

// File: rtl/lp_pkg.sv
package lp_pkg;

  typedef enum logic [1:0] {
    PS_RUN    = 2'd0,
    PS_HALT   = 2'd1,
    PS_SETTLE = 2'd2,
    PS_IDLE   = 2'd3
  } pwrState_t;

  // control -> datapath
  typedef struct packed {
    logic loadSettle;  // reload timer with settle count, restart prescaler
    logic timerRun;    // oscillator running: prescaler and timer advance
  } ctlStrb_t;

  // datapath -> control
  typedef struct packed {
    logic wakeEdge;    // synchronised rising edge on any wake port bit
    logic ckoRise;     // synchronised rising edge on clock-output pin
    logic tglTick;     // watched timer bit toggled this instruction cycle
    logic settleDone;  // settling count expired
  } dpStat_t;

endpackage

// File: rtl/lp_timer.sv
module lp_timer
  import lp_pkg::*;
#(
  parameter int DIV        = 10,
  parameter int TMR_W      = 16,
  parameter int TOGGLE_BIT = 12,
  parameter int SETTLE     = 256,
  parameter int WK_W       = 8
) (
  input  logic            clk,
  input  logic            rstN,
  input  ctlStrb_t        strb,
  input  logic            swPndClr,
  input  logic [WK_W-1:0] wakePort,
  input  logic            ckoPin,
  output dpStat_t         stat,
  output logic            t0Pnd
);

  localparam int PW = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [PW-1:0]    PRESC_LAST = PW'(DIV - 1);
  localparam logic [TMR_W-1:0] SETTLE_VAL = TMR_W'(SETTLE);
  localparam logic [TMR_W-1:0] ONE_VAL    = TMR_W'(1);

  logic [PW-1:0]    presc;
  logic [TMR_W-1:0] timer;
  logic [TMR_W-1:0] timerDec;
  logic             tick;

  logic [WK_W-1:0]  wkS1, wkS2, wkPrev;
  logic             ckS1, ckS2, ckPrev;

  // input synchronisers and edge registers
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wkS1   <= '0;
      wkS2   <= '0;
      wkPrev <= '0;
      ckS1   <= 1'b0;
      ckS2   <= 1'b0;
      ckPrev <= 1'b0;
    end else begin
      wkS1   <= wakePort;
      wkS2   <= wkS1;
      wkPrev <= wkS2;
      ckS1   <= ckoPin;
      ckS2   <= ckS1;
      ckPrev <= ckS2;
    end
  end

  // instruction-cycle prescaler
  assign tick = strb.timerRun && (presc == PRESC_LAST);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)               presc <= '0;
    else if (strb.loadSettle) presc <= '0;
    else if (tick)           presc <= '0;
    else if (strb.timerRun)  presc <= presc + 1'b1;
  end

  // shared idle timer, counting down
  assign timerDec = timer - 1'b1;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                timer <= '1;
    else if (strb.loadSettle) timer <= SETTLE_VAL;
    else if (tick)            timer <= timerDec;
  end

  // pending flag: toggle wins over clear
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)             t0Pnd <= 1'b0;
    else if (stat.tglTick) t0Pnd <= 1'b1;
    else if (swPndClr)     t0Pnd <= 1'b0;
  end

  always_comb begin
    stat.wakeEdge   = |(wkS2 & ~wkPrev);
    stat.ckoRise    = ckS2 & ~ckPrev;
    stat.tglTick    = tick && (timerDec[TOGGLE_BIT] != timer[TOGGLE_BIT]);
    stat.settleDone = tick && (timer == ONE_VAL);
  end

endmodule

// File: rtl/lp_ctrl.sv
module lp_ctrl
  import lp_pkg::*;
(
  input  logic     clk,
  input  logic     rstN,
  input  logic     cfgRcOsc,
  input  logic     cfgHaltDis,
  input  logic     swHaltWr,
  input  logic     swIdleWr,
  input  logic     swDlyWr,
  input  logic     swDlyVal,
  input  logic     t0En,
  input  logic     wdEnReq,
  input  logic     cmEnReq,
  input  logic     t0Pnd,
  input  dpStat_t  stat,
  output ctlStrb_t strb,
  output logic     coreClkEn,
  output logic     oscEn,
  output logic     wakePulse,
  output logic     haltFlag,
  output logic     idleFlag,
  output logic     t0Irq,
  output logic     wdEn,
  output logic     cmEn,
  output logic     ckiForceHigh,
  output logic     ckiDrvEn
);

  pwrState_t state, stateNxt;
  logic      clkDly;
  logic      haltWake;
  logic      needSettle;

  assign haltWake   = stat.wakeEdge || (stat.ckoRise && cfgRcOsc);
  assign needSettle = !cfgRcOsc || clkDly;

  always_comb begin
    stateNxt        = state;
    strb.loadSettle = 1'b0;
    strb.timerRun   = (state != PS_HALT);
    unique case (state)
      PS_RUN: begin
        if (swHaltWr && !cfgHaltDis) stateNxt = PS_HALT;
        else if (swIdleWr)           stateNxt = PS_IDLE;
      end
      PS_HALT: begin
        if (haltWake) begin
          if (needSettle) begin
            stateNxt        = PS_SETTLE;
            strb.loadSettle = 1'b1;
          end else begin
            stateNxt = PS_RUN;
          end
        end
      end
      PS_SETTLE: begin
        if (stat.settleDone) stateNxt = PS_RUN;
      end
      PS_IDLE: begin
        if (stat.wakeEdge || stat.tglTick) stateNxt = PS_RUN;
      end
      default: stateNxt = PS_RUN;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state     <= PS_RUN;
      wakePulse <= 1'b0;
      clkDly    <= 1'b0;
    end else begin
      state     <= stateNxt;
      wakePulse <= (stateNxt == PS_RUN) && (state != PS_RUN);
      if (swDlyWr) clkDly <= swDlyVal;
    end
  end

  always_comb begin
    coreClkEn    = (state == PS_RUN);
    oscEn        = (state != PS_HALT);
    haltFlag     = (state == PS_HALT) || (state == PS_SETTLE);
    idleFlag     = (state == PS_IDLE);
    t0Irq        = t0Pnd && t0En;
    wdEn         = wdEnReq && (state != PS_HALT);
    cmEn         = cmEnReq;
    ckiForceHigh = (state == PS_HALT) && cfgRcOsc;
    ckiDrvEn     = !((state == PS_HALT) && !cfgRcOsc);
  end

endmodule

// File: rtl/lp_wake_seq.sv
module lp_wake_seq
  import lp_pkg::*;
#(
  parameter int DIV        = 10,
  parameter int TMR_W      = 16,
  parameter int TOGGLE_BIT = 12,
  parameter int SETTLE     = 256,
  parameter int WK_W       = 8
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            cfgRcOsc,
  input  logic            cfgHaltDis,
  input  logic            swHaltWr,
  input  logic            swIdleWr,
  input  logic            swPndClr,
  input  logic            swDlyWr,
  input  logic            swDlyVal,
  input  logic            t0En,
  input  logic            wdEnReq,
  input  logic            cmEnReq,
  input  logic [WK_W-1:0] wakePort,
  input  logic            ckoPin,
  output logic            coreClkEn,
  output logic            oscEn,
  output logic            wakePulse,
  output logic            haltFlag,
  output logic            idleFlag,
  output logic            t0Pnd,
  output logic            t0Irq,
  output logic            wdEn,
  output logic            cmEn,
  output logic            ckiForceHigh,
  output logic            ckiDrvEn
);

  ctlStrb_t strb;
  dpStat_t  stat;

  lp_timer #(
    .DIV(DIV), .TMR_W(TMR_W), .TOGGLE_BIT(TOGGLE_BIT),
    .SETTLE(SETTLE), .WK_W(WK_W)
  ) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .swPndClr(swPndClr),
    .wakePort(wakePort), .ckoPin(ckoPin), .stat(stat), .t0Pnd(t0Pnd)
  );

  lp_ctrl u_ctl (
    .clk(clk), .rstN(rstN), .cfgRcOsc(cfgRcOsc), .cfgHaltDis(cfgHaltDis),
    .swHaltWr(swHaltWr), .swIdleWr(swIdleWr), .swDlyWr(swDlyWr),
    .swDlyVal(swDlyVal), .t0En(t0En), .wdEnReq(wdEnReq), .cmEnReq(cmEnReq),
    .t0Pnd(t0Pnd), .stat(stat), .strb(strb), .coreClkEn(coreClkEn),
    .oscEn(oscEn), .wakePulse(wakePulse), .haltFlag(haltFlag),
    .idleFlag(idleFlag), .t0Irq(t0Irq), .wdEn(wdEn), .cmEn(cmEn),
    .ckiForceHigh(ckiForceHigh), .ckiDrvEn(ckiDrvEn)
  );

endmodule

// File: rtl/lp_wake_seq_chk.sv
module lp_wake_seq_chk (
  input logic clk,
  input logic rstN,
  input logic cfgHaltDis,
  input logic cfgRcOsc,
  input logic swPndClr,
  input logic t0En,
  input logic wdEnReq,
  input logic cmEnReq,
  input logic coreClkEn,
  input logic oscEn,
  input logic wakePulse,
  input logic haltFlag,
  input logic idleFlag,
  input logic t0Pnd,
  input logic t0Irq,
  input logic wdEn,
  input logic cmEn,
  input logic ckiDrvEn
);

  // R2 / R7: any low-power flag means the core clock is gated
  a_r2_flags_gate_core: assert property (@(posedge clk) disable iff (!rstN)
    (haltFlag || idleFlag) |-> !coreClkEn);

  // R7: the oscillator keeps running through sleep
  a_r7_idle_osc_on: assert property (@(posedge clk) disable iff (!rstN)
    idleFlag |-> oscEn);

  // R3: with the stop state disabled, the stop flag cannot appear
  a_r3_halt_disabled: assert property (@(posedge clk) disable iff (!rstN)
    (cfgHaltDis && !haltFlag) |=> !haltFlag);

  // R8: pending flag holds until cleared
  a_r8_pnd_holds: assert property (@(posedge clk) disable iff (!rstN)
    (t0Pnd && !swPndClr) |=> t0Pnd);

  // R9: request only with pending and enable
  a_r9_irq_needs_pnd: assert property (@(posedge clk) disable iff (!rstN)
    t0Irq |-> (t0Pnd && t0En));

  // R11: watchdog off, monitor kept, pad control while oscillator stopped
  a_r11_wd_off_halt: assert property (@(posedge clk) disable iff (!rstN)
    (!oscEn && wdEnReq) |-> (!wdEn && (cmEn == cmEnReq)));

  a_r11_cki_crystal: assert property (@(posedge clk) disable iff (!rstN)
    (!oscEn && !cfgRcOsc) |-> !ckiDrvEn);

  // R12: wake pulse marks the first running cycle and lasts one cycle
  a_r12_pulse_first: assert property (@(posedge clk) disable iff (!rstN)
    wakePulse |-> (coreClkEn && !$past(coreClkEn)));

  a_r12_pulse_single: assert property (@(posedge clk) disable iff (!rstN)
    wakePulse |=> !wakePulse);

endmodule

bind lp_wake_seq lp_wake_seq_chk u_chk (
  .clk(clk), .rstN(rstN), .cfgHaltDis(cfgHaltDis), .cfgRcOsc(cfgRcOsc),
  .swPndClr(swPndClr), .t0En(t0En), .wdEnReq(wdEnReq), .cmEnReq(cmEnReq),
  .coreClkEn(coreClkEn), .oscEn(oscEn), .wakePulse(wakePulse),
  .haltFlag(haltFlag), .idleFlag(idleFlag), .t0Pnd(t0Pnd), .t0Irq(t0Irq),
  .wdEn(wdEn), .cmEn(cmEn), .ckiDrvEn(ckiDrvEn)
);

// File: tb/sim_lp_wake_seq.sv
`timescale 1ns/1ps
module sim_lp_wake_seq;

  localparam int DIV    = 3;
  localparam int TMR_W  = 8;
  localparam int TGL    = 4;
  localparam int SETTLE = 8;
  localparam int WK_W   = 4;
  localparam int PERIOD = DIV * (1 << TGL);
  localparam int SLOW   = DIV * SETTLE + 3;
  localparam int FAST   = 3;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic cfgRcOsc = 1'b0, cfgHaltDis = 1'b0;
  logic swHaltWr = 1'b0, swIdleWr = 1'b0, swPndClr = 1'b0;
  logic swDlyWr = 1'b0, swDlyVal = 1'b0;
  logic t0En = 1'b0, wdEnReq = 1'b1, cmEnReq = 1'b1;
  logic [WK_W-1:0] wakePort = '0;
  logic ckoPin = 1'b0;
  logic coreClkEn, oscEn, wakePulse, haltFlag, idleFlag;
  logic t0Pnd, t0Irq, wdEn, cmEn, ckiForceHigh, ckiDrvEn;

  int nChk = 0;
  int nFail = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  lp_wake_seq #(
    .DIV(DIV), .TMR_W(TMR_W), .TOGGLE_BIT(TGL), .SETTLE(SETTLE), .WK_W(WK_W)
  ) u0 (
    .clk(clk), .rstN(rstN), .cfgRcOsc(cfgRcOsc), .cfgHaltDis(cfgHaltDis),
    .swHaltWr(swHaltWr), .swIdleWr(swIdleWr), .swPndClr(swPndClr),
    .swDlyWr(swDlyWr), .swDlyVal(swDlyVal), .t0En(t0En),
    .wdEnReq(wdEnReq), .cmEnReq(cmEnReq), .wakePort(wakePort),
    .ckoPin(ckoPin), .coreClkEn(coreClkEn), .oscEn(oscEn),
    .wakePulse(wakePulse), .haltFlag(haltFlag), .idleFlag(idleFlag),
    .t0Pnd(t0Pnd), .t0Irq(t0Irq), .wdEn(wdEn), .cmEn(cmEn),
    .ckiForceHigh(ckiForceHigh), .ckiDrvEn(ckiDrvEn)
  );

  task automatic check(string req, string what, int act, int exp);
    nChk++;
    if (act != exp) begin
      nFail++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic strobeHalt();
    swHaltWr = 1'b1; cyc(1); swHaltWr = 1'b0;
  endtask

  task automatic strobeIdle();
    swIdleWr = 1'b1; cyc(1); swIdleWr = 1'b0;
  endtask

  task automatic strobeClr();
    swPndClr = 1'b1; cyc(1); swPndClr = 1'b0;
  endtask

  task automatic writeDly(logic v);
    swDlyWr = 1'b1; swDlyVal = v; cyc(1); swDlyWr = 1'b0;
  endtask

  // raise a wake source, count edges until the core clock returns
  task automatic measWake(string req, bit useCko, int expN);
    int n = 0;
    if (useCko) ckoPin = 1'b1; else wakePort[1] = 1'b1;
    while (n < 2000) begin
      @(posedge clk); n++;
      @(negedge clk);
      if (coreClkEn) break;
    end
    check(req, "edges to core clock", n, expN);
    check("R12", "wake pulse first cycle", int'(wakePulse), 1);
    check("R12", "flags clear", int'(haltFlag | idleFlag), 0);
    cyc(1);
    check("R12", "wake pulse single", int'(wakePulse), 0);
    ckoPin = 1'b0; wakePort = '0;
    cyc(4);
  endtask

  task automatic waitPnd();
    int n = 0;
    while (!t0Pnd && n < 4 * PERIOD) begin cyc(1); n++; end
  endtask

  task automatic tReset();
    cyc(3);
    check("R1", "core clock en", int'(coreClkEn), 1);
    check("R1", "osc en", int'(oscEn), 1);
    check("R1", "flags", int'(haltFlag | idleFlag), 0);
    check("R1", "pending/irq/pulse", int'(t0Pnd | t0Irq | wakePulse), 0);
  endtask

  task automatic tHaltDisabled();
    cfgHaltDis = 1'b1;
    strobeHalt();
    cyc(2);
    check("R3", "halt flag", int'(haltFlag), 0);
    check("R3", "core clock en", int'(coreClkEn), 1);
    cfgHaltDis = 1'b0;
  endtask

  task automatic tHaltCrystal();
    cfgRcOsc = 1'b0;
    strobeHalt();
    check("R2", "halt flag", int'(haltFlag), 1);
    check("R2", "core clock en", int'(coreClkEn), 0);
    check("R2", "osc en", int'(oscEn), 0);
    check("R11", "wd en in halt", int'(wdEn), 0);
    check("R11", "cm en in halt", int'(cmEn), 1);
    check("R11", "cki drv en crystal", int'(ckiDrvEn), 0);
    check("R11", "cki force high crystal", int'(ckiForceHigh), 0);
    ckoPin = 1'b1; cyc(10); ckoPin = 1'b0; cyc(4);
    check("R6", "cko ignored on crystal", int'(haltFlag & ~oscEn), 1);
    measWake("R4", 1'b0, SLOW);
    check("R11", "wd en back", int'(wdEn), 1);
  endtask

  task automatic tSettleWindow();
    // oscillator on but core gated while settling (R4)
    strobeHalt();
    wakePort[0] = 1'b1;
    cyc(6);
    check("R4", "osc en in settle", int'(oscEn), 1);
    check("R4", "core gated in settle", int'(coreClkEn), 0);
    check("R4", "halt flag in settle", int'(haltFlag), 1);
    cyc(SLOW);
    check("R4", "core back after settle", int'(coreClkEn), 1);
    wakePort = '0; cyc(4);
  endtask

  task automatic tHaltRc();
    cfgRcOsc = 1'b1;
    strobeHalt();
    check("R11", "cki force high rc", int'(ckiForceHigh), 1);
    check("R11", "cki drv en rc", int'(ckiDrvEn), 1);
    measWake("R5", 1'b1, FAST);     // R6: cko exit on R/C, no delay bit
    writeDly(1'b1);
    strobeHalt();
    measWake("R5", 1'b0, SLOW);
    writeDly(1'b0);
    cfgRcOsc = 1'b0;
  endtask

  task automatic tPeriodic();
    int n = 0;
    strobeClr();
    waitPnd();
    strobeClr();
    check("R8", "clear", int'(t0Pnd), 0);
    n = 1;
    while (!t0Pnd && n < 4 * PERIOD) begin cyc(1); n++; end
    check("R8", "toggle period", n, PERIOD);
    t0En = 1'b0; cyc(1);
    check("R9", "irq masked", int'(t0Irq), 0);
    t0En = 1'b1; cyc(1);
    check("R9", "irq raised", int'(t0Irq), 1);
    t0En = 1'b0;
  endtask

  task automatic tWakeIgnoredThenIdle();
    strobeClr();
    waitPnd();                  // quiet window of PERIOD clocks begins
    wakePort[2] = 1'b1; cyc(4); wakePort = '0; cyc(3);
    strobeIdle();
    cyc(5);
    check("R10", "run edge ignored", int'(idleFlag), 1);
    check("R7", "core gated in idle", int'(coreClkEn), 0);
    check("R7", "osc on in idle", int'(oscEn), 1);
    measWake("R7", 1'b0, FAST);
  endtask

  task automatic tIdleTick();
    int n = 0;
    strobeClr();
    strobeIdle();
    check("R7", "idle flag", int'(idleFlag), 1);
    while (idleFlag && n < PERIOD + 10) begin cyc(1); n++; end
    check("R8", "idle ended by tick", int'(idleFlag), 0);
    check("R8", "pending at idle exit", int'(t0Pnd), 1);
    check("R12", "wake pulse tick exit", int'(wakePulse), 1);
  endtask

  initial begin
    cyc(3);
    rstN = 1'b1;
    tReset();
    tHaltDisabled();
    tHaltCrystal();
    tSettleWindow();
    tHaltRc();
    tPeriodic();
    tWakeIgnoredThenIdle();
    tIdleTick();
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", nChk, nFail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      nChk++; nFail++;
      $display("FAIL all watchdog: actual=timeout expected=finish");
      $display("  [TB] %0d tests run, %0d failed", nChk, nFail);
      $finish;
    end
  end

endmodule